// File: doc/BRIEF.md
# Byte-Port System Control Register Block

This block sits on a narrow synchronous I/O bus and answers byte accesses at a fixed set of port addresses. One stand-alone port and one contiguous window of 82 ports are decoded. The block holds a few control bits, and each of these either drives a pin or can be read back. Writes to two ports fire one-cycle lock-toggle strobes toward an attached battery-backed memory. Several ports return fixed identification and configuration bytes when read.

A host issues a write by asserting `bus_wr` with an address and a data byte for one cycle. It issues a read by asserting `bus_rd`, and the byte is presented on `bus_rdata` one cycle later. Every address the block does not map reads as all ones. Writes to unmapped or read-only ports leave everything unchanged.

Top module: `sysreg_port_block`

## Requirements
- R1: After a synchronous reset, `hard_reset_o`, `disk_present_o`, `contig_map_o`, `lock_pulse_o`, `lock_code_o`, `bus_rdata`, the endian flag and the control nibble are all zero.
- R2: A write to 0x0092 copies data bit 0 to `hard_reset_o` and data bit 1 to the endian flag. A read of 0x0092 returns the endian flag in bit 1, and every other bit is zero.
- R3: A write to 0x0808 copies data bit 0 to `disk_present_o`.
- R4: Any write to 0x0810 produces a pulse on `lock_pulse_o` with `lock_code_o` = 2'b01. Any write to 0x0812 produces a pulse with `lock_code_o` = 2'b10. The data byte has no effect on either. The pulse is high for exactly the one cycle after the write edge. While `lock_pulse_o` is low, `lock_code_o` is 2'b00.
- R5: A write to 0x081C stores data bits 3:0. A read of 0x081C returns the stored nibble in bits 3:0, and bits 7:4 read as zero.
- R6: A write to 0x0850 latches data bit 0 onto `contig_map_o`. A read of 0x0850 returns that bit in bit 0, and every other bit is zero. `contig_map_o` changes only on such a write.
- R7: Reads return these fixed bytes: 0x0800 returns 0xEF, 0x0802 returns 0xAD, 0x0803 returns 0xE0, 0x080C returns 0x3C, 0x0810 returns 0x39, 0x0818 returns 0x00 and 0x0823 returns 0x03.
- R8: A read of any other address returns 0xFF. This includes 0x0814, unmapped ports inside the window, and addresses outside the decoded range.
- R9: Writes to 0x0800, 0x0802, 0x0803 and 0x0814 change no output and no stored state. The same holds for writes to addresses outside 0x0092 and 0x0800–0x0851.
- R10: `bus_rdata` updates only at a clock edge where `bus_rd` is high, one cycle after the strobe. It holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| hard_reset_o | output | 1 | Reset request level |
| disk_present_o | output | 1 | Disk-present status flag |
| contig_map_o | output | 1 | Contiguous memory map enable |
| lock_pulse_o | output | 1 | One-cycle lock-toggle strobe |
| lock_code_o | output | 2 | Lock-toggle code, valid with the strobe |

## Verification
Every piece of stored state reaches the ports within one cycle. A corrupted reset, disk or map bit shows directly on its pin at the edge after the write. A corrupted endian flag or control nibble shows on `bus_rdata` on the cycle after the next read of its port. A decode slip shows on that same read-back cycle, as a wrong constant or a missing 0xFF. The bench therefore reads every stored port back after each write. It also checks every pin after writes to neighbouring and ignored ports. A strobe that stretches, repeats or carries the wrong code is visible in the first or second cycle after the write.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  typedef enum logic [3:0] {
    P_NONE,
    P_SYSCTL,
    P_ID0,
    P_ID2,
    P_ID3,
    P_DISK,
    P_CFG,
    P_LOCK_A,
    P_LOCK_B,
    P_BLIND,
    P_ZERO,
    P_CTRL,
    P_MISC,
    P_CONTIG
  } port_e;

  localparam logic [7:0] RD_UNMAPPED = 8'hFF;
  localparam logic [7:0] RD_ID0      = 8'hEF;
  localparam logic [7:0] RD_ID2      = 8'hAD;
  localparam logic [7:0] RD_ID3      = 8'hE0;
  localparam logic [7:0] RD_CFG      = 8'h3C;
  localparam logic [7:0] RD_LOCK     = 8'h39;
  localparam logic [7:0] RD_ZERO     = 8'h00;
  localparam logic [7:0] RD_MISC     = 8'h03;

  localparam logic [1:0] LOCK_CODE_A = 2'b01;
  localparam logic [1:0] LOCK_CODE_B = 2'b10;

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SINGLE_PORT = 'h0092,
  parameter int WIN_BASE    = 'h0800,
  parameter int WIN_LEN     = 82
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             port
);
  localparam int OFF_W = $clog2(WIN_LEN);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  assign off    = addr - ADDR_W'(WIN_BASE);
  assign in_win = (addr >= ADDR_W'(WIN_BASE)) && (off < ADDR_W'(WIN_LEN));

  always_comb begin
    port = P_NONE;
    if (addr == ADDR_W'(SINGLE_PORT)) begin
      port = P_SYSCTL;
    end else if (in_win) begin
      case (off[OFF_W-1:0])
        OFF_W'(8'h00): port = P_ID0;
        OFF_W'(8'h02): port = P_ID2;
        OFF_W'(8'h03): port = P_ID3;
        OFF_W'(8'h08): port = P_DISK;
        OFF_W'(8'h0C): port = P_CFG;
        OFF_W'(8'h10): port = P_LOCK_A;
        OFF_W'(8'h12): port = P_LOCK_B;
        OFF_W'(8'h14): port = P_BLIND;
        OFF_W'(8'h18): port = P_ZERO;
        OFF_W'(8'h1C): port = P_CTRL;
        OFF_W'(8'h23): port = P_MISC;
        OFF_W'(8'h50): port = P_CONTIG;
        default:       port = P_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  port_e             port,
  input  logic [CTRL_W-1:0] wbits,
  output logic              hard_reset,
  output logic              endian,
  output logic              disk_present,
  output logic [CTRL_W-1:0] ctrl,
  output logic              contig,
  output logic              lock_pulse,
  output logic [1:0]        lock_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hard_reset   <= 1'b0;
      endian       <= 1'b0;
      disk_present <= 1'b0;
      ctrl         <= '0;
      contig       <= 1'b0;
      lock_pulse   <= 1'b0;
      lock_code    <= 2'b00;
    end else begin
      lock_pulse <= 1'b0;
      lock_code  <= 2'b00;
      if (wr_en) begin
        case (port)
          P_SYSCTL: begin
            hard_reset <= wbits[0];
            endian     <= wbits[1];
          end
          P_DISK:   disk_present <= wbits[0];
          P_CTRL:   ctrl         <= wbits;
          P_CONTIG: contig       <= wbits[0];
          P_LOCK_A: begin
            lock_pulse <= 1'b1;
            lock_code  <= LOCK_CODE_A;
          end
          P_LOCK_B: begin
            lock_pulse <= 1'b1;
            lock_code  <= LOCK_CODE_B;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: code is one-hot while the strobe is high and idle otherwise
  a_r4_code_with_pulse: assert property (@(posedge clk) disable iff (rst)
    lock_pulse |-> $onehot(lock_code));
  a_r4_code_idle: assert property (@(posedge clk) disable iff (rst)
    !lock_pulse |-> (lock_code == 2'b00));
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import sysreg_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  port_e             port,
  input  logic              endian,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              contig,
  output logic [7:0]        rdata
);
  logic [7:0] nxt;

  always_comb begin
    case (port)
      P_SYSCTL: nxt = {6'b0, endian, 1'b0};
      P_ID0:    nxt = RD_ID0;
      P_ID2:    nxt = RD_ID2;
      P_ID3:    nxt = RD_ID3;
      P_CFG:    nxt = RD_CFG;
      P_LOCK_A: nxt = RD_LOCK;
      P_ZERO:   nxt = RD_ZERO;
      P_CTRL:   nxt = 8'(ctrl);
      P_MISC:   nxt = RD_MISC;
      P_CONTIG: nxt = {7'b0, contig};
      default:  nxt = RD_UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= nxt;
  end

  // R10: read data holds while no read strobe arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rdata));
endmodule

// File: rtl/sysreg_port_block.sv
module sysreg_port_block
  import sysreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CTRL_W      = 4,
  parameter int SINGLE_PORT = 'h0092,
  parameter int WIN_BASE    = 'h0800,
  parameter int WIN_LEN     = 82
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              hard_reset_o,
  output logic              disk_present_o,
  output logic              contig_map_o,
  output logic              lock_pulse_o,
  output logic [1:0]        lock_code_o
);
  localparam logic [ADDR_W-1:0] A_SYS    = ADDR_W'(SINGLE_PORT);
  localparam logic [ADDR_W-1:0] A_LOCKA  = ADDR_W'(WIN_BASE + 'h10);
  localparam logic [ADDR_W-1:0] A_LOCKB  = ADDR_W'(WIN_BASE + 'h12);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(WIN_BASE + 'h1C);
  localparam logic [ADDR_W-1:0] A_CONTIG = ADDR_W'(WIN_BASE + 'h50);

  port_e             port;
  logic              endian;
  logic [CTRL_W-1:0] ctrl;

  sysreg_decode #(
    .ADDR_W(ADDR_W), .SINGLE_PORT(SINGLE_PORT),
    .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN)
  ) u_dec (
    .addr(bus_addr),
    .port(port)
  );

  sysreg_store #(.CTRL_W(CTRL_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .port(port),
    .wbits(bus_wdata[CTRL_W-1:0]),
    .hard_reset(hard_reset_o), .endian(endian),
    .disk_present(disk_present_o), .ctrl(ctrl), .contig(contig_map_o),
    .lock_pulse(lock_pulse_o), .lock_code(lock_code_o)
  );

  sysreg_rdmux #(.CTRL_W(CTRL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .port(port),
    .endian(endian), .ctrl(ctrl), .contig(contig_map_o),
    .rdata(bus_rdata)
  );

  // R2: reset request follows bit 0 of the latest accepted control write
  a_r2_reset_level: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && bus_wr && bus_addr == A_SYS)) |-> (hard_reset_o == $past(bus_wdata[0])));
  // R2: endian read-back has only bit 1 populated
  a_r2_endian_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && bus_rd && bus_addr == A_SYS)) |-> (bus_rdata[7:2] == 6'b0 && !bus_rdata[0]));
  // R4: a strobe is always caused by a lock-port write one cycle earlier
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    lock_pulse_o |-> $past(bus_wr && (bus_addr == A_LOCKA || bus_addr == A_LOCKB)));
  // R5: upper nibble of control read-back is zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && bus_rd && bus_addr == A_CTRL)) |-> (bus_rdata[7:4] == 4'h0));
  // R6: map enable moves only on a write to its port
  a_r6_contig_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr && bus_addr == A_CONTIG)) |-> $stable(contig_map_o));
endmodule

// File: tb/tb_sysreg_port_block.sv
module tb_sysreg_port_block;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        hard_reset_o, disk_present_o, contig_map_o, lock_pulse_o;
  logic [1:0]  lock_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysreg_port_block dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hard_reset_o(hard_reset_o),
    .disk_present_o(disk_present_o), .contig_map_o(contig_map_o),
    .lock_pulse_o(lock_pulse_o), .lock_code_o(lock_code_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [7:0] pins();
    return {2'b0, lock_code_o, lock_pulse_o, contig_map_o, disk_present_o, hard_reset_o};
  endfunction

  task automatic t_reset();
    chk("R1 pins", pins(), 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    begin logic [7:0] d; rd(16'h0092, d); chk("R1 endian", d, 8'h00);
      rd(16'h081C, d); chk("R1 ctrl", d, 8'h00); end
  endtask

  task automatic t_sysctl();
    logic [7:0] d;
    wr(16'h0092, 8'hFD); chk("R2 reset bit", {7'b0, hard_reset_o}, 8'h01);
    rd(16'h0092, d);     chk("R2 endian clear", d, 8'h00);
    wr(16'h0092, 8'h02); chk("R2 reset low", {7'b0, hard_reset_o}, 8'h00);
    rd(16'h0092, d);     chk("R2 endian set", d, 8'h02);
    wr(16'h0092, 8'h03); chk("R2 both", {7'b0, hard_reset_o}, 8'h01);
    wr(16'h0092, 8'h00);
  endtask

  task automatic t_disk();
    wr(16'h0808, 8'hA1); chk("R3 set", {7'b0, disk_present_o}, 8'h01);
    wr(16'h0808, 8'hFE); chk("R3 clear", {7'b0, disk_present_o}, 8'h00);
  endtask

  task automatic t_lock();
    wr(16'h0810, 8'h00);
    chk("R4 pulse A", {5'b0, lock_pulse_o, lock_code_o}, 8'h05);
    @(negedge clk); chk("R4 pulse A ends", {5'b0, lock_pulse_o, lock_code_o}, 8'h00);
    wr(16'h0812, 8'hA5);
    chk("R4 pulse B", {5'b0, lock_pulse_o, lock_code_o}, 8'h06);
    @(negedge clk); chk("R4 pulse B ends", {5'b0, lock_pulse_o, lock_code_o}, 8'h00);
    wr(16'h0810, 8'hFF);
    chk("R4 data ignored", {5'b0, lock_pulse_o, lock_code_o}, 8'h05);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(16'h081C, 8'hA5); rd(16'h081C, d); chk("R5 low nibble", d, 8'h05);
    wr(16'h081C, 8'hFA); rd(16'h081C, d); chk("R5 mask", d, 8'h0A);
  endtask

  task automatic t_contig();
    logic [7:0] d;
    wr(16'h0850, 8'hFF); chk("R6 pin set", {7'b0, contig_map_o}, 8'h01);
    rd(16'h0850, d);     chk("R6 read set", d, 8'h01);
    wr(16'h0850, 8'h0E); chk("R6 pin clear", {7'b0, contig_map_o}, 8'h00);
    rd(16'h0850, d);     chk("R6 read clear", d, 8'h00);
  endtask

  task automatic t_consts();
    logic [7:0] d;
    rd(16'h0800, d); chk("R7 0800", d, 8'hEF);
    rd(16'h0802, d); chk("R7 0802", d, 8'hAD);
    rd(16'h0803, d); chk("R7 0803", d, 8'hE0);
    rd(16'h080C, d); chk("R7 080C", d, 8'h3C);
    rd(16'h0810, d); chk("R7 0810", d, 8'h39);
    rd(16'h0818, d); chk("R7 0818", d, 8'h00);
    rd(16'h0823, d); chk("R7 0823", d, 8'h03);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(16'h0814, d); chk("R8 0814", d, 8'hFF);
    rd(16'h0801, d); chk("R8 0801", d, 8'hFF);
    rd(16'h0851, d); chk("R8 0851", d, 8'hFF);
    rd(16'h0852, d); chk("R8 0852", d, 8'hFF);
    rd(16'h0093, d); chk("R8 0093", d, 8'hFF);
    rd(16'h07FF, d); chk("R8 07FF", d, 8'hFF);
    rd(16'h0812, d); chk("R8 0812", d, 8'hFF);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(16'h081C, 8'h06); wr(16'h0808, 8'h01); wr(16'h0850, 8'h01);
    foreach (ign_list[i]) begin
      wr(ign_list[i], 8'hFF);
      chk("R9 pins", pins(), 8'h06);
    end
    rd(16'h081C, d); chk("R9 ctrl kept", d, 8'h06);
    rd(16'h0092, d); chk("R9 endian kept", d, 8'h00);
    rd(16'h0800, d); chk("R9 const kept", d, 8'hEF);
  endtask

  logic [15:0] ign_list [8] = '{16'h0800, 16'h0802, 16'h0803, 16'h0814,
                                 16'h0093, 16'h0852, 16'h07FF, 16'h1092};

  task automatic t_hold();
    logic [7:0] d;
    rd(16'h0802, d);
    repeat (3) @(negedge clk);
    chk("R10 hold idle", bus_rdata, 8'hAD);
    wr(16'h081C, 8'h09);
    chk("R10 hold on write", bus_rdata, 8'hAD);
    @(negedge clk); bus_addr = 16'h081C; bus_rd = 1'b1;
    @(posedge clk); #1 chk("R10 one cycle", bus_rdata, 8'h09);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sysctl();
    t_disk();
    t_lock();
    t_ctrl();
    t_contig();
    t_consts();
    t_unmapped();
    t_ignored();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule